// File: doc/BRIEF.md
# Carry-Skewed Pipelined Adder/Accumulator

This block adds two N-bit words, or adds one word into a running total, at full clock rate while keeping the logic between any two registers down to a single full adder. Each bit position has its own one-bit adder slice. The slice stores its sum bit and its carry in flip-flops, and the next slice up takes that stored carry one clock later. A word therefore ripples upward one bit per cycle.

To keep each slice working on the right word, bit k of every input is delayed k cycles before it reaches slice k. Each sum bit is then delayed N-1-k cycles after its slice, so that all bits of a result leave together. The carry out of the top slice is the overflow flag, and it appears in the same cycle as the sum word it belongs to. Every word is accepted on every clock and comes out a fixed N-1 cycles later.

In accumulate mode, each slice adds its operand bit to the sum bit it stored itself. This works because no information flows from higher bits back to lower ones. The accumulate/add choice is made per word and travels through the pipeline with that word's operand bits.

Top module: `pipe_skew_acc`

## Requirements
- R1: While `rst_n` is low, and for the N-1 cycles after it rises, `sum_o` and `ovf_o` are 0. A reset also clears the running total, so the first accumulate word after reset returns its own `op_a_i`.
- R2: A word with `acc_mode_i` = 0 (add) produces `sum_o` = (`op_a_i` + `op_b_i`) mod 2^N.
- R3: A word with `acc_mode_i` = 1 (accumulate) produces `sum_o` = (previous word's `sum_o` + `op_a_i`) mod 2^N, and its `op_b_i` has no effect.
- R4: The operands sampled at rising edge e give their result on the outputs right after edge e+N-1. A new word is accepted at every edge.
- R5: `ovf_o` is bit N of the (N+1)-bit sum of the same word. It appears in the same cycle as that word's `sum_o`, and when it is 1, `sum_o` is less than that word's `op_a_i`.
- R6: The mode is taken per word. Any mix of add and accumulate words gives the same results as applying R2 and R3 in order, one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a_i | input | WIDTH | Operand added in both modes |
| op_b_i | input | WIDTH | Second operand, used only in add mode |
| acc_mode_i | input | 1 | 0 = add `op_a_i` + `op_b_i`; 1 = add `op_a_i` to the previous result |
| sum_o | output | WIDTH | Aligned result word, N-1 cycles after its operands |
| ovf_o | output | 1 | Carry out of the top bit, aligned with `sum_o` |

## Verification
On every cycle, the bound checker compares `sum_o` and `ovf_o` with a word-level model delayed by N-1 cycles. It also holds the outputs at zero in the window after reset and checks that an overflow always leaves a result below the operand that caused it. What only the bench's scenarios show is behaviour across different conditions. This covers both a narrow and a wide instance, hand-picked wrap cases in the table, and an operand B that changes during accumulate words without effect. It also covers a reset in the middle of a stream that must discard a non-zero total and the words still in flight.

// File: rtl/pskew_pkg.sv
package pskew_pkg;

   typedef enum logic {
      MODE_ADD = 1'b0,
      MODE_ACC = 1'b1
   } acc_mode_e;

   // cycles an operand bit waits before reaching its slice
   function automatic int skew_depth(input int bit_idx);
      return bit_idx;
   endfunction

   // cycles a sum bit waits after its slice so the word leaves aligned
   function automatic int align_depth(input int width, input int bit_idx);
      return width - 1 - bit_idx;
   endfunction

endpackage

// File: rtl/pskew_delay.sv
module pskew_delay #(
   parameter int WIDTH = 1,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("pskew_delay: DEPTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/pskew_slice.sv
module pskew_slice
   import pskew_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      a_i,
   input  logic      b_i,
   input  acc_mode_e mode_i,
   input  logic      cin_i,
   output logic      sum_q,
   output logic      cout_q
);

   logic b_sel;
   logic sum_d;
   logic cout_d;

   // accumulate: own stored sum bit is the second operand
   always_comb begin
      b_sel  = (mode_i == MODE_ACC) ? sum_q : b_i;
      sum_d  = a_i ^ b_sel ^ cin_i;
      cout_d = (a_i & b_sel) | (a_i & cin_i) | (b_sel & cin_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q  <= 1'b0;
         cout_q <= 1'b0;
      end else begin
         sum_q  <= sum_d;
         cout_q <= cout_d;
      end
   end

endmodule

// File: rtl/pipe_skew_acc.sv
module pipe_skew_acc
   import pskew_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a_i,
   input  logic [WIDTH-1:0] op_b_i,
   input  logic             acc_mode_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             ovf_o
);

   localparam int LATENCY = WIDTH - 1;
   localparam int TOP     = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("pipe_skew_acc: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] carry_q;
   logic [WIDTH-1:0] slice_sum;

   for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      logic      a_sk;
      logic      b_sk;
      logic      m_sk;
      logic      cin;

      // input skew: bit k waits k cycles
      if (skew_depth(k) == 0) begin : g_noskew
         assign a_sk = op_a_i[k];
         assign b_sk = op_b_i[k];
         assign m_sk = acc_mode_i;
      end else begin : g_skew
         logic [2:0] sk_q;
         pskew_delay #(
            .WIDTH(3),
            .DEPTH(skew_depth(k))
         ) u_skew (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  ({acc_mode_i, op_b_i[k], op_a_i[k]}),
            .q_o  (sk_q)
         );
         assign a_sk = sk_q[0];
         assign b_sk = sk_q[1];
         assign m_sk = sk_q[2];
      end

      // carry enters from the registered carry of the slice below
      if (k == 0) begin : g_cin0
         assign cin = 1'b0;
      end else begin : g_cinn
         assign cin = carry_q[k-1];
      end

      pskew_slice u_slice (
         .clk   (clk),
         .rst_n (rst_n),
         .a_i   (a_sk),
         .b_i   (b_sk),
         .mode_i(acc_mode_e'(m_sk)),
         .cin_i (cin),
         .sum_q (slice_sum[k]),
         .cout_q(carry_q[k])
      );

      // output align: bit k waits WIDTH-1-k cycles
      if (align_depth(WIDTH, k) == 0) begin : g_noalign
         assign sum_o[k] = slice_sum[k];
      end else begin : g_align
         pskew_delay #(
            .WIDTH(1),
            .DEPTH(align_depth(WIDTH, k))
         ) u_align (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (slice_sum[k]),
            .q_o  (sum_o[k])
         );
      end
   end

   // top carry is produced in the same cycle the top sum bit is
   assign ovf_o = carry_q[TOP];

   if (LATENCY != TOP) begin : g_lat_mismatch
      $error("pipe_skew_acc: latency bookkeeping inconsistent");
   end

endmodule

// File: rtl/pskew_chk.sv
module pskew_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] op_a_i,
   input logic [WIDTH-1:0] op_b_i,
   input logic             acc_mode_i,
   input logic [WIDTH-1:0] sum_o,
   input logic             ovf_o
);

   localparam int L  = WIDTH - 1;
   localparam int CW = $clog2(WIDTH + 2) + 1;

   logic [WIDTH-1:0] ref_acc;
   logic [WIDTH:0]   ref_next;
   logic [WIDTH-1:0] sum_p [L+1];
   logic             ovf_p [L+1];
   logic [WIDTH-1:0] a_p   [L+1];
   logic [CW-1:0]    since_rst;

   always_comb begin
      ref_next = (acc_mode_i ? {1'b0, ref_acc} : {1'b0, op_b_i}) + {1'b0, op_a_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_acc   <= '0;
         since_rst <= '0;
         for (int i = 0; i <= L; i++) begin
            sum_p[i] <= '0;
            ovf_p[i] <= 1'b0;
            a_p[i]   <= '0;
         end
      end else begin
         ref_acc  <= ref_next[WIDTH-1:0];
         sum_p[0] <= ref_next[WIDTH-1:0];
         ovf_p[0] <= ref_next[WIDTH];
         a_p[0]   <= op_a_i;
         for (int i = 1; i <= L; i++) begin
            sum_p[i] <= sum_p[i-1];
            ovf_p[i] <= ovf_p[i-1];
            a_p[i]   <= a_p[i-1];
         end
         if (since_rst <= CW'(L)) since_rst <= since_rst + 1'b1;
      end
   end

   // R1
   reset_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst <= CW'(L)) |-> (sum_o == '0 && ovf_o == 1'b0));

   // R2 R3 R4 R6
   result_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_o == sum_p[L]);

   // R5
   ovf_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o == ovf_p[L]);

   // R5
   wrap_below_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (sum_o < a_p[L]));

   // R5
   zero_a_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_p[L] == '0) |-> !ovf_o);

endmodule

bind pipe_skew_acc pskew_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_a_i    (op_a_i),
   .op_b_i    (op_b_i),
   .acc_mode_i(acc_mode_i),
   .sum_o     (sum_o),
   .ovf_o     (ovf_o)
);

// File: tb/sim_pipe_skew_acc.sv
`timescale 1ns/1ps
module sim_pipe_skew_acc;

   localparam int L16 = 15;
   localparam int L3  = 2;
   localparam int NR  = 400;
   localparam int NT  = 10;

   typedef struct packed {
      logic        m;
      logic [15:0] a;
      logic [15:0] b;
      logic [15:0] s;
      logic        o;
   } vec_t;

   // mode, a, b, expected sum, expected ovf (running total starts at 0)
   localparam vec_t TBL [NT] = '{
      '{1'b0, 16'h1234, 16'h1111, 16'h2345, 1'b0},
      '{1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},
      '{1'b1, 16'h0010, 16'h0000, 16'h0010, 1'b0},
      '{1'b1, 16'h8000, 16'hFFFF, 16'h8010, 1'b0},
      '{1'b1, 16'h8000, 16'h0000, 16'h0010, 1'b1},
      '{1'b0, 16'hAAAA, 16'h5555, 16'hFFFF, 1'b0},
      '{1'b1, 16'h0001, 16'h0000, 16'h0000, 1'b1},
      '{1'b1, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0},
      '{1'b0, 16'h8000, 16'h8000, 16'h0000, 1'b1},
      '{1'b1, 16'h7FFF, 16'h1234, 16'h7FFF, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m16, m3;
   logic [15:0] a16, b16, s16;
   logic [2:0]  a3, b3, s3;
   logic        o16, o3;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [16:0] e16 [NR];
   logic [3:0]  e3  [NR];
   logic [15:0] acc16;
   logic [2:0]  acc3;

   always #5 clk = ~clk;

   pipe_skew_acc #(.WIDTH(16)) u0 (
      .clk(clk), .rst_n(rst_n), .op_a_i(a16), .op_b_i(b16),
      .acc_mode_i(m16), .sum_o(s16), .ovf_o(o16)
   );

   pipe_skew_acc #(.WIDTH(3)) u1 (
      .clk(clk), .rst_n(rst_n), .op_a_i(a3), .op_b_i(b3),
      .acc_mode_i(m3), .sum_o(s3), .ovf_o(o3)
   );

   task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   initial begin
      m16 = 0; a16 = 0; b16 = 0;
      m3 = 0; a3 = 0; b3 = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset sum w16", {1'b0, s16}, '0);
      chk("R1 reset ovf w16", {16'b0, o16}, '0);
      chk("R1 reset sum w3", {14'b0, s3}, '0);
      chk("R1 reset ovf w3", {16'b0, o3}, '0);
      rst_n = 1'b1;

      // table walk on the wide instance
      for (int c = 0; c < NT + L16 + 2; c++) begin
         int w;
         w = c - 1 - L16;
         if (w < 0) begin
            chk("R1 R4 pre-latency sum", {1'b0, s16}, '0);
         end else if (w < NT) begin
            if (TBL[w].m) chk("R3 table accumulate sum", {1'b0, s16}, {1'b0, TBL[w].s});
            else          chk("R2 table add sum", {1'b0, s16}, {1'b0, TBL[w].s});
            chk("R5 table ovf", {16'b0, o16}, {16'b0, TBL[w].o});
         end
         if (c < NT) begin
            m16 = TBL[c].m; a16 = TBL[c].a; b16 = TBL[c].b;
         end else begin
            m16 = 0; a16 = 0; b16 = 0;
         end
         @(negedge clk);
      end

      // random mixed stream on both widths
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      acc16 = '0;
      acc3  = '0;
      for (int c = 0; c < NR + L16 + 2; c++) begin
         int w16;
         int w3;
         w16 = c - 1 - L16;
         w3  = c - 1 - L3;
         if (w16 >= 0 && w16 < NR) begin
            chk("R6 R4 random sum w16", {1'b0, s16}, {1'b0, e16[w16][15:0]});
            chk("R5 random ovf w16", {16'b0, o16}, {16'b0, e16[w16][16]});
         end
         if (w3 >= 0 && w3 < NR) begin
            chk("R6 R4 random sum w3", {14'b0, s3}, {14'b0, e3[w3][2:0]});
            chk("R5 random ovf w3", {16'b0, o3}, {16'b0, e3[w3][3]});
         end
         if (c < NR) begin
            m16 = 1'($urandom); a16 = 16'($urandom); b16 = 16'($urandom);
            m3  = 1'($urandom); a3  = 3'($urandom);  b3  = 3'($urandom);
            e16[c] = (m16 ? {1'b0, acc16} : {1'b0, b16}) + {1'b0, a16};
            acc16  = e16[c][15:0];
            e3[c]  = (m3 ? {1'b0, acc3} : {1'b0, b3}) + {1'b0, a3};
            acc3   = e3[c][2:0];
         end else begin
            m16 = 0; a16 = 0; b16 = 0;
            m3 = 0; a3 = 0; b3 = 0;
         end
         @(negedge clk);
      end

      // reset in the middle of a non-zero accumulation
      m16 = 1; a16 = 16'h00F0; b16 = 16'h0F0F;
      m3 = 1; a3 = 3'd3; b3 = 3'd6;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-stream reset sum w16", {1'b0, s16}, '0);
      chk("R1 mid-stream reset sum w3", {14'b0, s3}, '0);
      rst_n = 1'b1;
      m16 = 1; a16 = 16'h0005; b16 = 16'hFFFF;
      m3 = 1; a3 = 3'd5; b3 = 3'd7;
      @(negedge clk);
      m16 = 0; a16 = 0; b16 = 0;
      m3 = 0; a3 = 0; b3 = 0;
      repeat (L3) @(negedge clk);
      chk("R1 R3 total cleared w3", {14'b0, s3}, 17'd5);
      chk("R5 no ovf after clear w3", {16'b0, o3}, '0);
      repeat (L16 - L3) @(negedge clk);
      chk("R1 R3 total cleared w16", {1'b0, s16}, 17'd5);
      chk("R5 no ovf after clear w16", {16'b0, o16}, '0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule